// File: doc/BRIEF.md
# Big-Endian Byte-Lane Data Memory

This block is a synchronous RAM model for a 32-bit processor. It holds four regions of 256 longwords each. Region 0 holds code, region 1 data and region 2 stack; region 3 is reserved. The core addresses the memory in bytes, and consecutive longwords sit four byte addresses apart. Each core access is a byte, a word or a longword. Sub-word data is placed in the byte lanes big-endian: the byte at offset 0 of a longword occupies bits 31:24. A write changes only the lanes that the access covers. A read brings the addressed lanes down to bit 0 and sign-extends byte and word results to 32 bits.

A mode input decides who owns the memory. While the test harness owns it, before and after a program runs, the harness writes whole longwords by longword index and reads any location back. This is how a program is loaded and how the final state is dumped. While the core owns it, the harness port is ignored.

All accesses take effect on the falling clock edge, so the core can prepare the address and data on the rising edge. An access outside the four regions is flagged on an error output, and so is an access that crosses a longword boundary. Such an access writes nothing, and if it is a read it returns zero.

Top module: `be_lane_ram`

## Requirements
- R1: While `rst` is high at a falling edge, `core_rdata` and `host_rdata` are cleared to zero and `core_err` is cleared low.
- R2: With `host_mode`=1 (the harness owns the memory), `host_we`=1 writes all 32 bits of `host_wdata` to the longword at index `host_addr`, and at each falling edge `host_rdata` takes the content of that longword. Core enables are ignored: nothing is written, `core_rdata` holds its value and `core_err` stays low.
- R3: With `host_mode`=0 (the core owns the memory), `host_we` has no effect on the memory contents.
- R4: The size code on `core_size` is 00 for byte, 01 for word, 10 for longword and 11 for reserved. A core write at byte offset k (`core_addr[1:0]`) places the low byte of `core_wdata` in bits 31-8k:24-8k. A word write at offset k places the low 16 bits in bytes k and k+1, where byte 0 is bits 31:24. A longword write fills the whole word. Lanes that the access does not cover keep their previous contents.
- R5: A core read (`core_re`=1, `core_we`=0) returns the addressed lanes shifted down to bit 0 in `core_rdata` after the falling edge. Byte and word results are sign-extended to 32 bits.
- R6: A core access whose byte address is 4096 or above sets `core_err` after that falling edge and writes nothing. If it is a read, `core_rdata` becomes zero.
- R7: A word access at offset 3, a longword access at a nonzero offset, or any access with size code 11 sets `core_err`, writes nothing and, if it is a read, returns zero.
- R8: When `core_we` and `core_re` are both high, the write is performed and `core_rdata` holds its previous value.
- R9: A falling edge in core mode with neither enable high leaves `core_rdata` unchanged and drives `core_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses occur on its falling edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| host_mode | input | 1 | 1: the harness owns the memory; 0: the core owns it |
| host_addr | input | 10 | Harness longword index |
| host_we | input | 1 | Harness longword write enable |
| host_wdata | input | 32 | Harness write data |
| host_rdata | output | 32 | Harness read data |
| core_addr | input | 32 | Core byte address |
| core_size | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 reserved |
| core_wdata | input | 32 | Core write data, right-aligned |
| core_re | input | 1 | Core read enable |
| core_we | input | 1 | Core write enable |
| core_rdata | output | 32 | Core read data, right-aligned and sign-extended |
| core_err | output | 1 | Address out of range or misaligned on the last access |

## Verification
The interesting case is a core write and a core read in the same falling edge. The bench first reads a known longword, then raises both enables on another address. It judges the result from two sides: `core_rdata` must still show the earlier read, and a later harness dump must show the new data. A second overlap is an error together with a write: an out-of-range or misaligned store must raise `core_err`, and a harness readback of the word it would alias or straddle must show no change.

// File: rtl/be_mem_pkg.sv
package be_mem_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int ADDR_W = 32;
    localparam int SHIFT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        acc_size_e         size;
        logic [DATA_W-1:0] wdata;
        logic              re;
        logic              we;
    } core_req_t;

    typedef struct packed {
        logic               valid;
        logic [LANES-1:0]   lanes;
        logic [SHIFT_W-1:0] shift;
    } lane_plan_t;

    typedef struct packed {
        logic               en;
        logic [LANES-1:0]   lanes;
        logic [DATA_W-1:0]  data;
    } wr_beat_t;

    function automatic int size_bytes(acc_size_e sz);
        case (sz)
            SZ_BYTE: return 1;
            SZ_WORD: return 2;
            SZ_LONG: return 4;
            default: return 0;
        endcase
    endfunction

    // Lane bit l covers data bits 8l+7:8l; offset 0 maps to the top lane.
    function automatic lane_plan_t plan_lanes(acc_size_e sz, logic [1:0] ofs);
        lane_plan_t p;
        int n;
        int low;
        n   = size_bytes(sz);
        low = LANES - int'(ofs) - n;
        p.valid = (n != 0) && (low >= 0);
        if (p.valid) begin
            p.lanes = LANES'(((1 << n) - 1) << low);
            p.shift = SHIFT_W'(low * 8);
        end else begin
            p.lanes = '0;
            p.shift = '0;
        end
        return p;
    endfunction

    function automatic logic [DATA_W-1:0] sign_fit(acc_size_e sz, logic [DATA_W-1:0] v);
        case (sz)
            SZ_BYTE: return {{(DATA_W-8){v[7]}}, v[7:0]};
            SZ_WORD: return {{(DATA_W-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/be_addr_decode.sv
module be_addr_decode
    import be_mem_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    output logic [IDX_W-1:0]  idx,
    output lane_plan_t        plan,
    output logic              ok
);
    logic in_range;

    always_comb begin
        in_range = (addr >> (IDX_W + 2)) == '0;
        idx      = addr[IDX_W+1:2];
        plan     = plan_lanes(size, addr[1:0]);
        ok       = in_range && plan.valid;
    end

endmodule

// File: rtl/be_lane_pack.sv
module be_lane_pack
    import be_mem_pkg::*;
(
    input  logic [DATA_W-1:0] wdata,
    input  lane_plan_t        plan,
    output logic [DATA_W-1:0] lane_data
);
    always_comb lane_data = wdata << plan.shift;
endmodule

// File: rtl/be_lane_extract.sv
module be_lane_extract
    import be_mem_pkg::*;
(
    input  logic [DATA_W-1:0] word,
    input  lane_plan_t        plan,
    input  acc_size_e         size,
    output logic [DATA_W-1:0] value
);
    always_comb value = sign_fit(size, word >> plan.shift);
endmodule

// File: rtl/be_bus_owner.sv
module be_bus_owner
    import be_mem_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic              host_mode,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [IDX_W-1:0]  core_idx,
    input  logic              core_wr_ok,
    input  lane_plan_t        core_plan,
    input  logic [DATA_W-1:0] core_lane_data,
    output logic [IDX_W-1:0]  wr_idx,
    output wr_beat_t          beat
);
    always_comb begin
        if (host_mode) begin
            wr_idx     = host_idx;
            beat.en    = host_we;
            beat.lanes = '1;
            beat.data  = host_wdata;
        end else begin
            wr_idx     = core_idx;
            beat.en    = core_wr_ok;
            beat.lanes = core_plan.lanes;
            beat.data  = core_lane_data;
        end
    end
endmodule

// File: rtl/be_lane_ram.sv
module be_lane_ram
    import be_mem_pkg::*;
#(
    parameter int REGIONS      = 4,
    parameter int REGION_WORDS = 256,
    localparam int DEPTH = REGIONS * REGION_WORDS,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [31:0]       core_addr,
    input  logic [1:0]        core_size,
    input  logic [31:0]       core_wdata,
    input  logic              core_re,
    input  logic              core_we,
    output logic [31:0]       core_rdata,
    output logic              core_err
);
    logic [DATA_W-1:0] mem [DEPTH];

    core_req_t         req;
    logic [IDX_W-1:0]  core_idx;
    lane_plan_t        plan;
    logic              acc_ok;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] rd_value;
    logic [IDX_W-1:0]  wr_idx;
    wr_beat_t          beat;
    logic              core_active;
    logic              core_bad;
    logic              core_rd_go;
    logic              core_wr_ok;

    always_comb begin
        req.addr    = core_addr;
        req.size    = acc_size_e'(core_size);
        req.wdata   = core_wdata;
        req.re      = core_re;
        req.we      = core_we;
        core_active = !host_mode && (req.re || req.we);
        core_bad    = core_active && !acc_ok;
        core_wr_ok  = !host_mode && req.we && acc_ok;
        core_rd_go  = !host_mode && req.re && !req.we;
    end

    be_addr_decode #(.DEPTH(DEPTH)) u_decode (
        .addr (req.addr),
        .size (req.size),
        .idx  (core_idx),
        .plan (plan),
        .ok   (acc_ok)
    );

    be_lane_pack u_pack (
        .wdata     (req.wdata),
        .plan      (plan),
        .lane_data (lane_data)
    );

    be_lane_extract u_extract (
        .word  (mem[core_idx]),
        .plan  (plan),
        .size  (req.size),
        .value (rd_value)
    );

    be_bus_owner #(.IDX_W(IDX_W)) u_owner (
        .host_mode      (host_mode),
        .host_idx       (host_addr),
        .host_we        (host_we),
        .host_wdata     (host_wdata),
        .core_idx       (core_idx),
        .core_wr_ok     (core_wr_ok),
        .core_plan      (plan),
        .core_lane_data (lane_data),
        .wr_idx         (wr_idx),
        .beat           (beat)
    );

    // Storage: lane-enabled write on the falling edge.
    always_ff @(negedge clk) begin
        if (beat.en) begin
            for (int l = 0; l < LANES; l++) begin
                if (beat.lanes[l]) begin
                    mem[wr_idx][8*l +: 8] <= beat.data[8*l +: 8];
                end
            end
        end
    end

    // Output registers: also on the falling edge, reset synchronously.
    always_ff @(negedge clk) begin
        if (rst) begin
            core_rdata <= '0;
            core_err   <= 1'b0;
            host_rdata <= '0;
        end else begin
            core_err <= core_bad;
            if (core_rd_go) begin
                core_rdata <= acc_ok ? rd_value : '0;
            end
            if (host_mode) begin
                host_rdata <= mem[host_addr];
            end
        end
    end

endmodule

// File: rtl/be_lane_ram_chk.sv
module be_lane_ram_chk #(
    parameter int REGIONS      = 4,
    parameter int REGION_WORDS = 256,
    localparam int IDX_W = $clog2(REGIONS * REGION_WORDS),
    localparam logic [31:0] SPAN = 32'(REGIONS * REGION_WORDS * 4)
) (
    input logic             clk,
    input logic             rst,
    input logic             host_mode,
    input logic [IDX_W-1:0] host_addr,
    input logic             host_we,
    input logic [31:0]      host_rdata,
    input logic [31:0]      core_addr,
    input logic [1:0]       core_size,
    input logic             core_re,
    input logic             core_we,
    input logic [31:0]      core_rdata,
    input logic             core_err
);
    logic misaligned;
    assign misaligned = (core_size == 2'b11) ||
                        (core_size == 2'b10 && core_addr[1:0] != 2'b00) ||
                        (core_size == 2'b01 && core_addr[1:0] == 2'b11);

    p_reset_clear_r1: assert property (@(negedge clk)
        rst |=> (core_rdata == '0 && !core_err && host_rdata == '0));

    p_host_owns_r2: assert property (@(negedge clk) disable iff (rst)
        host_mode |=> (!core_err && $stable(core_rdata)));

    p_range_err_r6: assert property (@(negedge clk) disable iff (rst)
        (!host_mode && (core_re || core_we) && core_addr >= SPAN) |=> core_err);

    p_range_zero_r6: assert property (@(negedge clk) disable iff (rst)
        (!host_mode && core_re && !core_we && core_addr >= SPAN) |=> core_rdata == '0);

    p_misalign_err_r7: assert property (@(negedge clk) disable iff (rst)
        (!host_mode && (core_re || core_we) && misaligned) |=> core_err);

    p_both_hold_r8: assert property (@(negedge clk) disable iff (rst)
        (!host_mode && core_re && core_we) |=> $stable(core_rdata));

    p_idle_quiet_r9: assert property (@(negedge clk) disable iff (rst)
        (!host_mode && !core_re && !core_we) |=> (!core_err && $stable(core_rdata)));

endmodule

bind be_lane_ram be_lane_ram_chk #(
    .REGIONS      (REGIONS),
    .REGION_WORDS (REGION_WORDS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_mode  (host_mode),
    .host_addr  (host_addr),
    .host_we    (host_we),
    .host_rdata (host_rdata),
    .core_addr  (core_addr),
    .core_size  (core_size),
    .core_re    (core_re),
    .core_we    (core_we),
    .core_rdata (core_rdata),
    .core_err   (core_err)
);

// File: tb/test_be_lane_ram.sv
`timescale 1ns/100ps
module test_be_lane_ram;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_mode;
    logic [9:0]  host_addr;
    logic        host_we;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic [31:0] core_addr;
    logic [1:0]  core_size;
    logic [31:0] core_wdata;
    logic        core_re;
    logic        core_we;
    logic [31:0] core_rdata;
    logic        core_err;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [1:0] SB = 2'b00, SW = 2'b01, SL = 2'b10, SX = 2'b11;

    always #2.5 clk = ~clk;

    be_lane_ram i_be_lane_ram (
        .clk        (clk),
        .rst        (rst),
        .host_mode  (host_mode),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .core_addr  (core_addr),
        .core_size  (core_size),
        .core_wdata (core_wdata),
        .core_re    (core_re),
        .core_we    (core_we),
        .core_rdata (core_rdata),
        .core_err   (core_err)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs set one ns after a rising edge act at the falling edge that follows.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(logic [9:0] idx, logic [31:0] d);
        host_mode = 1'b1; host_addr = idx; host_wdata = d; host_we = 1'b1;
        step();
        host_we = 1'b0;
    endtask

    task automatic host_read(logic [9:0] idx, output logic [31:0] d);
        host_mode = 1'b1; host_addr = idx;
        step();
        d = host_rdata;
    endtask

    task automatic core_op(logic [31:0] a, logic [1:0] sz, logic [31:0] wd, logic re, logic we);
        host_mode = 1'b0; core_addr = a; core_size = sz; core_wdata = wd;
        core_re = re; core_we = we;
        step();
        core_re = 1'b0; core_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 core_rdata", core_rdata, 32'h0);
        check("R1 core_err", {31'b0, core_err}, 32'h0);
        check("R1 host_rdata", host_rdata, 32'h0);
    endtask

    task automatic t_host_port();
        logic [31:0] d;
        host_write(10'h000, 32'h1111_2222);
        host_write(10'h3FF, 32'hA5A5_0F0F);
        host_read(10'h000, d); check("R2 readback idx 0", d, 32'h1111_2222);
        host_read(10'h3FF, d); check("R2 readback idx 3FF", d, 32'hA5A5_0F0F);
        // core enables while the harness owns the memory
        host_mode = 1'b1; host_addr = 10'h000;
        core_addr = 32'h0; core_size = SL; core_wdata = 32'hDEAD_BEEF;
        core_we = 1'b1; core_re = 1'b1;
        step();
        core_we = 1'b0; core_re = 1'b0;
        check("R2 core_err low in host mode", {31'b0, core_err}, 32'h0);
        check("R2 core_rdata held in host mode", core_rdata, 32'h0);
        host_read(10'h000, d); check("R2 core write ignored", d, 32'h1111_2222);
    endtask

    task automatic t_host_ignored();
        logic [31:0] d;
        host_mode = 1'b0; host_addr = 10'h000; host_wdata = 32'h0; host_we = 1'b1;
        step();
        host_we = 1'b0;
        host_read(10'h000, d); check("R3 host write ignored in core mode", d, 32'h1111_2222);
    endtask

    task automatic t_write_lanes();
        logic [31:0] d;
        host_write(10'h100, 32'h1122_3344);
        core_op(32'h400, SB, 32'h0000_00B5, 1'b0, 1'b1);
        host_read(10'h100, d); check("R4 byte offset 0", d, 32'hB522_3344);
        core_op(32'h401, SW, 32'h0000_0404, 1'b0, 1'b1);
        host_read(10'h100, d); check("R4 word offset 1", d, 32'hB504_0444);
        core_op(32'h403, SB, 32'h0000_0001, 1'b0, 1'b1);
        host_read(10'h100, d); check("R4 byte offset 3", d, 32'hB504_0401);
        host_write(10'h101, 32'h0);
        core_op(32'h406, SW, 32'h1234_BEEF, 1'b0, 1'b1);
        host_read(10'h101, d); check("R4 word offset 2", d, 32'h0000_BEEF);
        core_op(32'h408, SL, 32'h1234_5678, 1'b0, 1'b1);
        host_read(10'h102, d); check("R4 longword", d, 32'h1234_5678);
    endtask

    task automatic t_read_extract();
        core_op(32'h400, SB, 32'h0, 1'b1, 1'b0); check("R5 byte 0 sign", core_rdata, 32'hFFFF_FFB5);
        check("R5 no error", {31'b0, core_err}, 32'h0);
        core_op(32'h403, SB, 32'h0, 1'b1, 1'b0); check("R5 byte 3", core_rdata, 32'h0000_0001);
        core_op(32'h402, SB, 32'h0, 1'b1, 1'b0); check("R5 byte 2", core_rdata, 32'h0000_0004);
        core_op(32'h401, SW, 32'h0, 1'b1, 1'b0); check("R5 word 1", core_rdata, 32'h0000_0404);
        core_op(32'h400, SW, 32'h0, 1'b1, 1'b0); check("R5 word 0 sign", core_rdata, 32'hFFFF_B504);
        core_op(32'h406, SW, 32'h0, 1'b1, 1'b0); check("R5 word 2 sign", core_rdata, 32'hFFFF_BEEF);
        core_op(32'h400, SL, 32'h0, 1'b1, 1'b0); check("R5 longword", core_rdata, 32'hB504_0401);
    endtask

    task automatic t_range();
        logic [31:0] d;
        core_op(32'h1000, SL, 32'h0, 1'b1, 1'b0);
        check("R6 read err", {31'b0, core_err}, 32'h1);
        check("R6 read zero", core_rdata, 32'h0);
        core_op(32'h1000, SL, 32'hFFFF_FFFF, 1'b0, 1'b1);
        check("R6 write err", {31'b0, core_err}, 32'h1);
        host_read(10'h000, d); check("R6 no aliased write", d, 32'h1111_2222);
        core_op(32'hFFFF_FFFF, SB, 32'h0, 1'b1, 1'b0);
        check("R6 top address err", {31'b0, core_err}, 32'h1);
    endtask

    task automatic t_misalign();
        logic [31:0] d;
        core_op(32'h400, SL, 32'h0, 1'b1, 1'b0);
        core_op(32'h403, SW, 32'h0, 1'b1, 1'b0);
        check("R7 word offset 3 err", {31'b0, core_err}, 32'h1);
        check("R7 word offset 3 zero", core_rdata, 32'h0);
        core_op(32'h402, SL, 32'hFFFF_FFFF, 1'b0, 1'b1);
        check("R7 long offset 2 err", {31'b0, core_err}, 32'h1);
        host_read(10'h100, d); check("R7 no straddling write", d, 32'hB504_0401);
        core_op(32'h400, SX, 32'h0, 1'b1, 1'b0);
        check("R7 reserved size err", {31'b0, core_err}, 32'h1);
    endtask

    task automatic t_both();
        logic [31:0] d;
        core_op(32'h400, SL, 32'h0, 1'b1, 1'b0);
        check("R8 setup read", core_rdata, 32'hB504_0401);
        core_op(32'h404, SL, 32'hCAFE_F00D, 1'b1, 1'b1);
        check("R8 read data held", core_rdata, 32'hB504_0401);
        check("R8 no error", {31'b0, core_err}, 32'h0);
        host_read(10'h101, d); check("R8 write performed", d, 32'hCAFE_F00D);
    endtask

    task automatic t_idle();
        core_op(32'h408, SL, 32'h0, 1'b1, 1'b0);
        check("R9 setup read", core_rdata, 32'h1234_5678);
        core_op(32'h400, SX, 32'h0, 1'b1, 1'b0);
        check("R9 setup err", {31'b0, core_err}, 32'h1);
        core_addr = 32'h400; core_size = SL;
        step();
        check("R9 idle err low", {31'b0, core_err}, 32'h0);
        check("R9 idle data held", core_rdata, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; host_mode = 1'b1; host_addr = '0; host_we = 1'b0; host_wdata = '0;
        core_addr = '0; core_size = SL; core_wdata = '0; core_re = 1'b0; core_we = 1'b0;
        repeat (3) step();
        t_reset();
        rst = 1'b0;
        t_host_port();
        t_host_ignored();
        t_write_lanes();
        t_read_extract();
        t_range();
        t_misalign();
        t_both();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule